// File: doc/BRIEF.md
# Trimmable RTC Seconds Predivider

This block turns a 32.768 kHz clock-enable stream into a one-second tick. A 16-bit predivider counts down on each enabled cycle. When it underflows from zero it raises a tick and reloads. Most seconds reload with the nominal value 0x7FFF, which gives 32768 enabled cycles per second.

Once per trim period, the reload instead takes a software-programmed trim value. That one second is then lengthened or shortened to correct for crystal drift. The trim period is 64 seconds when the mode input selects counter operation and 60 seconds when it selects calendar operation.

Software reaches the trim register through a single 32-bit write/read port. A write is accepted only while the external write-ready flag is high. The block also drives a flag that stays high for the whole of each trimmed second.

Top module: `rtc_trim_prediv`

## Requirements
- R1: After reset, `rd_data` reads the trim reset value (0x0000_7FFF by default), and `sec_tick` and `trim_active` are low. The first tick comes after NOMINAL+1 enabled cycles.
- R2: Every second that is not a trim second lasts exactly NOMINAL+1 enabled cycles (32768 by default).
- R3: With `cal_mode`=0 (counter mode), seconds number 64, 128, 192 and so on after reset are trim seconds. Second number 0 is the first.
- R4: With `cal_mode`=1 (calendar mode), seconds number 60, 120 and so on after reset are trim seconds.
- R5: A trim second lasts trim+1 enabled cycles. A trim value above NOMINAL lengthens it, and a value below NOMINAL shortens it.
- R6: A write with `wr_en`=1 while `wr_ready`=0 changes neither `rd_data` nor the length of any later second.
- R7: The trim value sits in bits 15:0 of the word. Bits 31:16 always read zero, and data written to them is discarded.
- R8: The trim value is sampled at the moment of the trim reload. A write that lands during a second takes effect only at the next trim reload. A write accepted on a clock edge shows on `rd_data` one cycle later.
- R9: The predivider advances only on cycles with `clk_en`=1. `sec_tick` is a one-cycle pulse in the cycle after an enabled cycle in which the predivider was zero.
- R10: `trim_active` rises together with the tick that starts a trim second. It stays high until the tick that ends that second, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | 32.768 kHz enable pulse stream |
| cal_mode | input | 1 | 0 = 64-second trim period, 1 = 60-second trim period |
| wr_ready | input | 1 | Write-ready flag; writes are ignored while it is low |
| wr_en | input | 1 | Trim register write strobe |
| wr_data | input | 32 | Write data; bits 15:0 are the trim value |
| rd_data | output | 32 | Trim register read value, upper half zero |
| sec_tick | output | 1 | One-cycle pulse per second |
| trim_active | output | 1 | High for the duration of each trimmed second |

## Verification
A wrong predivider count shows up as a tick that moves by a whole number of enabled cycles. A wrong second counter or mode decode moves the trim second, which appears as `trim_active` rising on the wrong tick. Both are caught at the first tick or trim boundary after the fault, because the bench predicts every tick and every `trim_active` edge cycle by cycle. Register faults show on `rd_data` one cycle after the write. When the trim value is sampled at the wrong time, the next trim second has the wrong length.

// File: rtl/rtc_trim_pkg.sv
// Package: shared mode type and helpers for the trimmable RTC predivider.
// Assumes the trim period counts fit the second-counter width chosen by the top.
package rtc_trim_pkg;

    typedef enum logic {
        MODE_COUNTER  = 1'b0,
        MODE_CALENDAR = 1'b1
    } rtc_mode_e;

    // Width needed to hold a position 0..period-1.
    function automatic int sec_width(input int period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

endpackage

// File: rtl/rtc_trim_reg.sv
// Module: holds the software trim value.
// A write is accepted only while wr_ready is high. Only the low TRIM_W bits
// are stored; the remaining read bits are zero. Assumes DATA_W >= TRIM_W.
module rtc_trim_reg #(
    parameter int DATA_W = 32,
    parameter int TRIM_W = 16,
    parameter logic [TRIM_W-1:0] TRIM_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TRIM_W-1:0] trim_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - TRIM_W;

    logic accept;

    // Decide whether this cycle's write is taken.
    always_comb begin
        accept = wr_en && wr_ready;
    end

    // Store the trim field on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_q <= TRIM_RESET;
        end else if (accept) begin
            trim_q <= wr_data[TRIM_W-1:0];
        end
    end

    // Build the read word, padding the upper field with zeros when present.
    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, trim_q};
        end else begin : g_nopad
            assign rd_data = trim_q;
        end
    endgenerate

endmodule

// File: rtl/rtc_prediv_counter.sv
// Module: down-counting predivider.
// Decrements on each enabled cycle. On an enabled cycle at zero it flags an
// underflow and reloads either the nominal value or the trim value, as
// load_trim selects. Assumes load_trim is valid in the underflow cycle.
module rtc_prediv_counter #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] NOMINAL = 16'h7FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             load_trim,
    input  logic [CNT_W-1:0] trim_val,
    output logic             underflow
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_val;

    // Underflow happens on an enabled cycle while the count is zero.
    always_comb begin
        underflow  = clk_en && (cnt_q == '0);
        reload_val = load_trim ? trim_val : NOMINAL;
    end

    // Count down, or reload on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= NOMINAL;
        end else if (underflow) begin
            cnt_q <= reload_val;
        end else if (clk_en) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/rtc_period_seq.sv
// Module: tracks the position of the current second within the trim period.
// Asks for a trim reload at the wrap, and registers the tick and the
// trim-second flag. The wrap compares with >=, so a mode change that leaves
// the count beyond the new limit still wraps at the next second.
module rtc_period_seq #(
    parameter int CNT_PERIOD = 64,
    parameter int CAL_PERIOD = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow,
    input  logic cal_mode,
    output logic use_trim,
    output logic sec_tick,
    output logic trim_active
);
    import rtc_trim_pkg::*;

    localparam int MAX_PERIOD = (CNT_PERIOD > CAL_PERIOD) ? CNT_PERIOD : CAL_PERIOD;
    localparam int SEC_W = sec_width(MAX_PERIOD);
    localparam logic [SEC_W-1:0] CNT_LAST = SEC_W'(CNT_PERIOD - 1);
    localparam logic [SEC_W-1:0] CAL_LAST = SEC_W'(CAL_PERIOD - 1);

    rtc_mode_e        mode;
    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] last_sel;

    // Select the wrap point for the current mode.
    always_comb begin
        mode     = rtc_mode_e'(cal_mode);
        last_sel = (mode == MODE_CALENDAR) ? CAL_LAST : CNT_LAST;
        use_trim = (sec_q >= last_sel);
    end

    // Advance the second position, register the tick and the trim flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q       <= '0;
            sec_tick    <= 1'b0;
            trim_active <= 1'b0;
        end else begin
            sec_tick <= underflow;
            if (underflow) begin
                if (use_trim) begin
                    sec_q       <= '0;
                    trim_active <= 1'b1;
                end else begin
                    sec_q       <= sec_q + 1'b1;
                    trim_active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_trim_prediv.sv
// Module: top of the trimmable RTC seconds predivider.
// Assumes clk_en pulses at 32.768 kHz in the system clock domain. The
// wr_ready flag comes from the domain-crossing logic outside this block.
module rtc_trim_prediv #(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter logic [CNT_W-1:0] NOMINAL    = 16'h7FFF,
    parameter logic [CNT_W-1:0] TRIM_RESET = 16'h7FFF,
    parameter int CNT_PERIOD = 64,
    parameter int CAL_PERIOD = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              cal_mode,
    input  logic              wr_ready,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sec_tick,
    output logic              trim_active
);

    logic [CNT_W-1:0] trim_q;
    logic             underflow;
    logic             use_trim;

    rtc_trim_reg #(
        .DATA_W    (DATA_W),
        .TRIM_W    (CNT_W),
        .TRIM_RESET(TRIM_RESET)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ready(wr_ready),
        .wr_data (wr_data),
        .trim_q  (trim_q),
        .rd_data (rd_data)
    );

    rtc_prediv_counter #(
        .CNT_W  (CNT_W),
        .NOMINAL(NOMINAL)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .load_trim(use_trim),
        .trim_val (trim_q),
        .underflow(underflow)
    );

    rtc_period_seq #(
        .CNT_PERIOD(CNT_PERIOD),
        .CAL_PERIOD(CAL_PERIOD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .underflow  (underflow),
        .cal_mode   (cal_mode),
        .use_trim   (use_trim),
        .sec_tick   (sec_tick),
        .trim_active(trim_active)
    );

endmodule

// File: rtl/rtc_trim_prediv_chk.sv
// Checker: port-level properties of the trimmable predivider, bound to the top.
module rtc_trim_prediv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_en,
    input logic        wr_ready,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        sec_tick,
    input logic        trim_active
);

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:16] == 16'h0000);

    p_ignore_unready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(rd_data));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready) |=> (rd_data[15:0] == $past(wr_data[15:0])));

    p_tick_after_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !sec_tick);

    p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !clk_en) |=> !sec_tick);

    p_trim_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trim_active) |-> sec_tick);

    p_trim_leave_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trim_active) |-> sec_tick);

endmodule

bind rtc_trim_prediv rtc_trim_prediv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .wr_ready   (wr_ready),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .sec_tick   (sec_tick),
    .trim_active(trim_active)
);

// File: tb/rtc_trim_prediv_bench.sv
// Bench: runs a small configuration (15 as the nominal reload) through whole trim
// periods in both modes. Every tick and every trim-flag edge is predicted
// arithmetically from the enabled-cycle count.
module rtc_trim_prediv_bench;

    localparam logic [15:0] NOM  = 16'd15;
    localparam logic [15:0] TRST = 16'd15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        cal_mode = 1'b0;
    logic        wr_ready = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sec_tick;
    logic        trim_active;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit gate_en = 1'b1;
    string tag = "R2";

    // model state
    int          m_sec;
    int          m_pos;
    int          m_len;
    logic [15:0] m_trim;
    logic        exp_tick;
    logic        exp_act;

    always #5 clk = ~clk;

    rtc_trim_prediv #(
        .NOMINAL   (NOM),
        .TRIM_RESET(TRST)
    ) u_rtc_trim_prediv (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .cal_mode   (cal_mode),
        .wr_ready   (wr_ready),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .sec_tick   (sec_tick),
        .trim_active(trim_active)
    );

    task automatic report(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference: second k lasts trim+1 enables when k is a positive multiple of the period.
    always @(posedge clk) begin
        int period;
        period = cal_mode ? 60 : 64;
        if (!rst_n) begin
            m_sec    = 0;
            m_pos    = 0;
            m_len    = NOM + 1;
            m_trim   = TRST;
            exp_tick = 1'b0;
            exp_act  = 1'b0;
        end else begin
            exp_tick = 1'b0;
            if (clk_en) begin
                if (m_pos == m_len - 1) begin
                    exp_tick = 1'b1;
                    m_sec++;
                    m_pos   = 0;
                    exp_act = (m_sec % period) == 0;
                    m_len   = exp_act ? int'(m_trim) + 1 : int'(NOM) + 1;
                end else begin
                    m_pos++;
                end
            end
            if (wr_en && wr_ready) m_trim = wr_data[15:0];
        end
    end

    // Compare outputs away from the edge.
    always @(negedge clk) begin
        cyc++;
        clk_en <= gate_en && ((cyc % 5) != 2);
        if (rst_n) begin
            if (exp_tick || sec_tick !== exp_tick) report({tag, " tick"}, 32'(sec_tick), 32'(exp_tick));
            if (trim_active !== exp_act) report("R10 trim_active", 32'(trim_active), 32'(exp_act));
        end
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_secs(input int n);
        int target;
        target = m_sec + n;
        while (m_sec < target) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d, input logic rdy);
        @(negedge clk);
        wr_data  = d;
        wr_ready = rdy;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
        wr_ready = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n    = 1'b0;
        cal_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1 reset state
        do_reset(1'b0);
        report("R1 rd_data", rd_data, {16'h0, TRST});
        report("R1 sec_tick", 32'(sec_tick), 32'h0);
        report("R1 trim_active", 32'(trim_active), 32'h0);

        // R2 nominal seconds, counter mode, trim at reset value
        tag = "R2";
        wait_secs(10);

        // R7 upper half discarded; R5 lengthen via trim above nominal
        write_word(32'hABCD_0000 | 32'(NOM + 16'd5), 1'b1);
        report("R7 rd_data", rd_data, 32'(NOM + 16'd5));

        // R6 unready write ignored
        write_word(32'h0000_0003, 1'b0);
        report("R6 rd_data", rd_data, 32'(NOM + 16'd5));

        // R3 first trim second (second 64) lengthened
        tag = "R3";
        wait_secs(60);

        // R9 gap in enables: no ticks while clk_en low
        tag = "R9";
        gate_en = 1'b0;
        repeat (60) @(negedge clk);
        report("R9 no tick while gated", 32'(sec_tick), 32'h0);
        gate_en = 1'b1;

        // R8 mid-second write: shorten, takes effect at the next trim reload
        tag = "R8";
        wait_secs(3);
        repeat (4) @(negedge clk);
        write_word(32'(NOM - 16'd9), 1'b1);
        report("R8 rd_data", rd_data, 32'(NOM - 16'd9));
        tag = "R5";
        wait_secs(65);

        // R4 calendar mode with a one-cycle trim second
        do_reset(1'b1);
        report("R1 rd_data after reset", rd_data, {16'h0, TRST});
        write_word(32'h0000_0000, 1'b1);
        tag = "R4";
        wait_secs(125);

        // R4 calendar mode with a longer trim second
        write_word(32'(NOM + 16'd20), 1'b1);
        wait_secs(62);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule